// File: doc/BRIEF.md
# Peripheral Interrupt Acknowledge Responder

This block sits on the device side of a processor bus and answers the processor's interrupt acknowledge cycle on behalf of one interrupting peripheral. The peripheral raises a request through a single-cycle pulse. The block then holds that request as pending and presents it to the processor on `irq_out`. The processor later runs a special acknowledge cycle. That cycle is marked by an all-ones function code, all-ones upper address bits and the priority level being acknowledged on three low address bits. When the level matches the block's own and a request is pending, the block answers the cycle.

Software loads three settings through a simple load port: an 8-bit vector, a 3-bit priority level and a mode bit. In vectored mode the block drives its vector onto the data bus and raises the data acknowledge. In autovector mode it raises the valid-peripheral-address output instead, and the processor forms the vector from the level. Once the address strobe drops, the block releases the bus and clears the request. A request that arrives while a cycle is being answered is kept and presented after that cycle ends.

All bus inputs are active-high and are sampled on the rising clock edge. Every output is registered.

Top module: `irq_ack_responder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_out`, `data_oe`, `dtack` and `vpa` are 0 and `data_out` is 8'h00.
- R2: A 1 on `req_in` at a clock edge when no response is in progress makes `irq_out` 1 after that edge. It stays 1 until the acknowledge that serves it completes.
- R3: An acknowledge cycle is recognised only when `bus_fc` equals 3'b111 and `bus_addr_hi` equals 4'hF. With any other value, no output responds.
- R4: The block responds only when `bus_addr_lvl` equals its configured level.
- R5: A response starts only at an edge where `bus_as` is 1, `bus_rd` is 1 (1 means read) and a request is already pending.
- R6: In vectored mode (mode bit 0), the edge that accepts the cycle sets `dtack` and `data_oe` to 1 and `data_out` to the configured vector, with `vpa` at 0. These values hold while `bus_as` stays 1.
- R7: In autovector mode (mode bit 1), the accepting edge sets `vpa` to 1, while `dtack` and `data_oe` stay 0 and `data_out` stays 8'h00.
- R8: At the first edge where `bus_as` is 0 during a response, `data_oe`, `dtack` and `vpa` return to 0 and `data_out` returns to 8'h00. At that same edge `irq_out` drops, unless R9 applies.
- R9: A `req_in` pulse that arrives during a response does not change the current response. Once that response completes, `irq_out` remains 1, and the held request can be acknowledged by a later cycle.
- R10: A 1 on `cfg_load` at an edge loads `cfg_vector`, `cfg_level` and `cfg_auto`. Later acknowledge cycles are decoded and answered using the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the configuration |
| cfg_vector | input | 8 | Vector to be supplied in vectored mode |
| cfg_level | input | 3 | Priority level of this device |
| cfg_auto | input | 1 | 1 selects autovector mode, 0 selects vectored mode |
| req_in | input | 1 | Request pulse from the peripheral |
| bus_as | input | 1 | Address strobe, 1 while asserted |
| bus_rd | input | 1 | 1 for a read cycle |
| bus_fc | input | 3 | Processor function code |
| bus_addr_hi | input | 4 | Address bits 16 to 19 |
| bus_addr_lvl | input | 3 | Address bits 1 to 3, the level being acknowledged |
| irq_out | output | 1 | Pending request presented to the processor |
| data_out | output | 8 | Vector byte for the data bus |
| data_oe | output | 1 | Data bus drive enable |
| dtack | output | 1 | Data acknowledge |
| vpa | output | 1 | Valid peripheral address, requests an autovector |

## Verification
The bench presents near-miss acknowledge cycles, each differing from a valid one in a single field: one function-code bit clear, one upper address bit clear, the wrong level, a write instead of a read, or no request pending. A decoder that skipped any one of these terms would answer the cycle and raise `dtack`. In one test a request pulse arrives while an autovector response is still in progress. A design that dropped that request would lower `irq_out` when the strobe ends and ignore the next acknowledge. A design that applied it at once would disturb the response already under way. Finally, the level is reprogrammed while a request is pending. A design that kept the old level, or latched the vector too early, would answer the wrong cycle or drive a stale byte.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int VEC_W = 8;
    localparam int LVL_W = 3;
    localparam int FC_W  = 3;
    localparam int AHI_W = 4;

    typedef enum logic {
        MODE_VECTORED = 1'b0,
        MODE_AUTO     = 1'b1
    } ack_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ack_state_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic [LVL_W-1:0] level;
        ack_mode_e        mode;
    } ack_cfg_t;

    typedef struct packed {
        logic             oe;
        logic [VEC_W-1:0] data;
        logic             dtack;
        logic             vpa;
    } ack_resp_t;

    function automatic ack_resp_t build_resp(input ack_cfg_t c);
        ack_resp_t r;
        r = '0;
        if (c.mode == MODE_AUTO) begin
            r.vpa = 1'b1;
        end else begin
            r.oe    = 1'b1;
            r.data  = c.vector;
            r.dtack = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ack_cfg.sv
module irq_ack_cfg
    import irq_ack_pkg::*;
#(
    parameter logic [VEC_W-1:0] RST_VECTOR = 8'h0F,
    parameter logic [LVL_W-1:0] RST_LEVEL  = 3'd0,
    parameter logic             RST_AUTO   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [VEC_W-1:0] vector_in,
    input  logic [LVL_W-1:0] level_in,
    input  logic             auto_in,
    output ack_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.vector <= RST_VECTOR;
            cfg.level  <= RST_LEVEL;
            cfg.mode   <= ack_mode_e'(RST_AUTO);
        end else if (load) begin
            cfg.vector <= vector_in;
            cfg.level  <= level_in;
            cfg.mode   <= ack_mode_e'(auto_in);
        end
    end

endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
    import irq_ack_pkg::*;
(
    input  logic             bus_as,
    input  logic             bus_rd,
    input  logic [FC_W-1:0]  bus_fc,
    input  logic [AHI_W-1:0] bus_addr_hi,
    input  logic [LVL_W-1:0] bus_addr_lvl,
    input  logic [LVL_W-1:0] own_level,
    output logic             hit
);

    logic space_ok;
    logic level_ok;

    always_comb begin
        space_ok = (&bus_fc) && (&bus_addr_hi);
        level_ok = (bus_addr_lvl == own_level);
        hit      = bus_as && bus_rd && space_ok && level_ok;
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_in,
    input  logic      bus_as,
    input  logic      hit,
    input  ack_cfg_t  cfg,
    output logic      pending,
    output ack_resp_t resp
);

    ack_state_e state_q;
    logic       pending_q;
    logic       deferred_q;
    ack_resp_t  resp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pending_q  <= 1'b0;
            deferred_q <= 1'b0;
            resp_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (hit && pending_q) begin
                        state_q    <= ST_RESP;
                        resp_q     <= build_resp(cfg);
                        deferred_q <= req_in;
                    end else if (req_in) begin
                        pending_q <= 1'b1;
                    end
                end
                ST_RESP: begin
                    if (!bus_as) begin
                        state_q    <= ST_IDLE;
                        resp_q     <= '0;
                        pending_q  <= deferred_q || req_in;
                        deferred_q <= 1'b0;
                    end else if (req_in) begin
                        deferred_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pending = pending_q;
    assign resp    = resp_q;

    // R5
    start_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(resp_q.dtack || resp_q.vpa) |-> $past(hit && pending_q));

    // R7
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_q.dtack, resp_q.vpa}));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP && !bus_as) |=> (resp_q == '0));

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP && !bus_as && !deferred_q && !req_in) |=> !pending_q);

    // R6
    vector_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP && bus_as) |=> $stable(resp_q.data));

    // R9
    deferred_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP && !bus_as && deferred_q) |=> pending_q);

endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder
    import irq_ack_pkg::*;
#(
    parameter logic [VEC_W-1:0] RST_VECTOR = 8'h0F,
    parameter logic [LVL_W-1:0] RST_LEVEL  = 3'd0,
    parameter logic             RST_AUTO   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic             cfg_auto,
    input  logic             req_in,
    input  logic             bus_as,
    input  logic             bus_rd,
    input  logic [FC_W-1:0]  bus_fc,
    input  logic [AHI_W-1:0] bus_addr_hi,
    input  logic [LVL_W-1:0] bus_addr_lvl,
    output logic             irq_out,
    output logic [VEC_W-1:0] data_out,
    output logic             data_oe,
    output logic             dtack,
    output logic             vpa
);

    ack_cfg_t  cfg;
    logic      hit;
    logic      pending;
    ack_resp_t resp;

    irq_ack_cfg #(
        .RST_VECTOR(RST_VECTOR),
        .RST_LEVEL (RST_LEVEL),
        .RST_AUTO  (RST_AUTO)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .vector_in(cfg_vector),
        .level_in (cfg_level),
        .auto_in  (cfg_auto),
        .cfg      (cfg)
    );

    irq_ack_decode u_decode (
        .bus_as      (bus_as),
        .bus_rd      (bus_rd),
        .bus_fc      (bus_fc),
        .bus_addr_hi (bus_addr_hi),
        .bus_addr_lvl(bus_addr_lvl),
        .own_level   (cfg.level),
        .hit         (hit)
    );

    irq_ack_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req_in (req_in),
        .bus_as (bus_as),
        .hit    (hit),
        .cfg    (cfg),
        .pending(pending),
        .resp   (resp)
    );

    assign irq_out  = pending;
    assign data_out = resp.data;
    assign data_oe  = resp.oe;
    assign dtack    = resp.dtack;
    assign vpa      = resp.vpa;

endmodule

// File: tb/tb_irq_ack_responder.sv
module tb_irq_ack_responder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_vector = 8'h00;
    logic [2:0] cfg_level = 3'd0;
    logic       cfg_auto = 1'b0;
    logic       req_in = 1'b0;
    logic       bus_as = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_fc = 3'b000;
    logic [3:0] bus_addr_hi = 4'h0;
    logic [2:0] bus_addr_lvl = 3'd0;
    logic       irq_out;
    logic [7:0] data_out;
    logic       data_oe;
    logic       dtack;
    logic       vpa;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic       irq;
        logic       oe;
        logic [7:0] d;
        logic       dt;
        logic       vp;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    irq_ack_responder dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_vector(cfg_vector),
        .cfg_level(cfg_level), .cfg_auto(cfg_auto), .req_in(req_in),
        .bus_as(bus_as), .bus_rd(bus_rd), .bus_fc(bus_fc),
        .bus_addr_hi(bus_addr_hi), .bus_addr_lvl(bus_addr_lvl),
        .irq_out(irq_out), .data_out(data_out), .data_oe(data_oe),
        .dtack(dtack), .vpa(vpa)
    );

    // monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (irq_out !== e.irq || data_oe !== e.oe || data_out !== e.d ||
                    dtack !== e.dt || vpa !== e.vp) begin
                    n_fail++;
                    $display("FAIL %s: got irq=%b oe=%b d=%h dtack=%b vpa=%b, expected irq=%b oe=%b d=%h dtack=%b vpa=%b",
                             e.tag, irq_out, data_oe, data_out, dtack, vpa,
                             e.irq, e.oe, e.d, e.dt, e.vp);
                end
            end
        end
    end

    task automatic cyc(input logic irq, input logic oe, input logic [7:0] d,
                       input logic dt, input logic vp, input string tag);
        exp_t e;
        e.irq = irq; e.oe = oe; e.d = d; e.dt = dt; e.vp = vp; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_in   = 1'b0;
        cfg_load = 1'b0;
    endtask

    task automatic bus(input logic as, input logic rd, input logic [2:0] fc,
                       input logic [3:0] hi, input logic [2:0] lvl);
        bus_as = as; bus_rd = rd; bus_fc = fc; bus_addr_hi = hi; bus_addr_lvl = lvl;
    endtask

    task automatic idle_bus();
        bus(1'b0, 1'b0, 3'b000, 4'h0, 3'd0);
    endtask

    task automatic load_cfg(input logic [7:0] v, input logic [2:0] l, input logic a);
        cfg_load = 1'b1; cfg_vector = v; cfg_level = l; cfg_auto = a;
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state
        cyc(0, 0, 8'h00, 0, 0, "R1 reset");
        cyc(0, 0, 8'h00, 0, 0, "R1 reset");
        rst = 1'b0;
        cyc(0, 0, 8'h00, 0, 0, "R1 after reset");

        // R10 program vectored, level 3, vector A5
        load_cfg(8'hA5, 3'd3, 1'b0);
        cyc(0, 0, 8'h00, 0, 0, "R10 load");

        // R5 no pending request: valid cycle ignored
        bus(1, 1, 3'b111, 4'hF, 3'd3);
        cyc(0, 0, 8'h00, 0, 0, "R5 no pending");
        idle_bus();
        cyc(0, 0, 8'h00, 0, 0, "R5 idle");

        // R2 request raises irq
        req_in = 1'b1;
        cyc(1, 0, 8'h00, 0, 0, "R2 request");
        cyc(1, 0, 8'h00, 0, 0, "R2 held");

        // R3 wrong function code
        bus(1, 1, 3'b110, 4'hF, 3'd3);
        cyc(1, 0, 8'h00, 0, 0, "R3 fc");
        idle_bus(); cyc(1, 0, 8'h00, 0, 0, "R3 idle");
        // R3 wrong high address
        bus(1, 1, 3'b111, 4'hE, 3'd3);
        cyc(1, 0, 8'h00, 0, 0, "R3 addr_hi");
        idle_bus(); cyc(1, 0, 8'h00, 0, 0, "R3 idle");
        // R4 wrong level
        bus(1, 1, 3'b111, 4'hF, 3'd2);
        cyc(1, 0, 8'h00, 0, 0, "R4 level");
        idle_bus(); cyc(1, 0, 8'h00, 0, 0, "R4 idle");
        // R5 write cycle
        bus(1, 0, 3'b111, 4'hF, 3'd3);
        cyc(1, 0, 8'h00, 0, 0, "R5 write");
        idle_bus(); cyc(1, 0, 8'h00, 0, 0, "R5 idle");

        // R6 vectored response held over strobe
        bus(1, 1, 3'b111, 4'hF, 3'd3);
        cyc(1, 1, 8'hA5, 1, 0, "R6 accept");
        cyc(1, 1, 8'hA5, 1, 0, "R6 hold");
        cyc(1, 1, 8'hA5, 1, 0, "R6 hold");
        // R8 release and irq drop
        idle_bus();
        cyc(0, 0, 8'h00, 0, 0, "R8 release");
        // R5 request consumed: next cycle ignored
        bus(1, 1, 3'b111, 4'hF, 3'd3);
        cyc(0, 0, 8'h00, 0, 0, "R5 consumed");
        idle_bus(); cyc(0, 0, 8'h00, 0, 0, "R5 idle");

        // R7 autovector mode, level 5
        load_cfg(8'h3C, 3'd5, 1'b1);
        cyc(0, 0, 8'h00, 0, 0, "R10 load auto");
        req_in = 1'b1;
        cyc(1, 0, 8'h00, 0, 0, "R2 request");
        bus(1, 1, 3'b111, 4'hF, 3'd5);
        cyc(1, 0, 8'h00, 0, 1, "R7 accept");
        // R9 request during response
        req_in = 1'b1;
        cyc(1, 0, 8'h00, 0, 1, "R9 during");
        cyc(1, 0, 8'h00, 0, 1, "R9 during");
        idle_bus();
        cyc(1, 0, 8'h00, 0, 0, "R9 kept after release");
        cyc(1, 0, 8'h00, 0, 0, "R9 kept");
        bus(1, 1, 3'b111, 4'hF, 3'd5);
        cyc(1, 0, 8'h00, 0, 1, "R9 second ack");
        idle_bus();
        cyc(0, 0, 8'h00, 0, 0, "R8 release auto");

        // R10 reprogram while pending
        req_in = 1'b1;
        cyc(1, 0, 8'h00, 0, 0, "R2 request");
        load_cfg(8'h81, 3'd1, 1'b0);
        cyc(1, 0, 8'h00, 0, 0, "R10 reload");
        bus(1, 1, 3'b111, 4'hF, 3'd5);
        cyc(1, 0, 8'h00, 0, 0, "R10 old level ignored");
        idle_bus(); cyc(1, 0, 8'h00, 0, 0, "R10 idle");
        bus(1, 1, 3'b111, 4'hF, 3'd1);
        cyc(1, 1, 8'h81, 1, 0, "R10 new level vector");
        idle_bus();
        cyc(0, 0, 8'h00, 0, 0, "R8 release");
        cyc(0, 0, 8'h00, 0, 0, "R8 idle");

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule